// File: doc/BRIEF.md
# Fused Multiply-Add Significand Datapath

This block does the exact arithmetic of a fused multiply-add, z ± x·y, for operands that are already known to be normal numbers with their hidden bits set. It multiplies the two 53-bit significands into a full-width 128-bit product and applies no rounding to it. It then aligns the product against z with shifts that keep a sticky bit, and adds or subtracts the two. Finally it normalizes the result so that its leading one sits at a fixed place. A separate rounder receives the sign, an unbiased exponent and a 56-bit significand: 53 bits followed by guard, round and sticky.

Exponents arrive as unbiased two's-complement numbers. A flag marks z as zero, and in that case the block passes the normalized product straight through. A second flag negates the product, which turns the add into a subtract. A third flag tells the block that the rounding direction is toward negative infinity. The block only needs this to choose the sign of an exact-zero difference. Special operands (NaN, infinity, subnormal) and the final rounding and packing are handled elsewhere. The block is a two-stage pipeline. It accepts one operation per clock and raises `out_valid` two cycles after `in_valid`.

Top module: `fma_mant_core`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after the `in_valid` that produced it. A synchronous `rst` clears all valid state, and inputs presented while `rst` is high produce no output.
- R2: The product sign is `x_sign ^ y_sign ^ negate_prod`. When `z_is_zero` is 1, the output is the product alone: its sign, exponent `x_exp + y_exp` (plus one when the significand product is 2 or more), and its leading 56 bits.
- R3: When `z_is_zero` is 1, the values on `z_sign`, `z_exp` and `z_mant` have no effect on the output.
- R4: For a nonzero result, `out_sig` holds the leading 56 bits of the exact value of z ± x·y, with the leading one at bit 55. Bit 0 is ORed with every discarded lower bit. `out_exp` is the weight of that leading one, so the value is approximately `out_sig · 2^(out_exp−55)`. Significand inputs carry the hidden one at bit 52.
- R5: When the signs agree and the aligned sum reaches the next binade, the output exponent is one above the larger input exponent.
- R6: When the signs differ, the result takes the sign of the operand with the larger magnitude.
- R7: An exact-zero difference gives `out_sig` = 0 and `out_exp` = 0. Its sign is 1 when `round_down` is 1 and 0 otherwise.
- R8: An operand that lies more than 128 binades below the other collapses to a single sticky one. A far-smaller product gives `{z_mant, 3'b001}` when the signs match and `{z_mant−1, 3'b111}` when they differ, in both cases with `out_exp = z_exp`.
- R9: Deep cancellation is normalized in one step: any nonzero result has `out_sig[55]` = 1, even when the difference has lost more than 64 leading bits.
- R10: Operations presented on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| negate_prod | input | 1 | Subtract the product instead of adding it |
| round_down | input | 1 | Rounding direction is toward negative infinity |
| x_sign | input | 1 | Sign of x |
| x_exp | input | EXP_W | Unbiased exponent of x, two's complement |
| x_mant | input | 53 | Significand of x, hidden one at bit 52 |
| y_sign | input | 1 | Sign of y |
| y_exp | input | EXP_W | Unbiased exponent of y |
| y_mant | input | 53 | Significand of y |
| z_sign | input | 1 | Sign of z |
| z_exp | input | EXP_W | Unbiased exponent of z |
| z_mant | input | 53 | Significand of z |
| z_is_zero | input | 1 | z is zero; the z fields are ignored |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W+2 | Unbiased result exponent, two's complement |
| out_sig | output | 56 | Normalized significand plus guard, round and sticky bits |

## Verification
In the second stage, alignment sticky, carry renormalization and leading-zero normalization can all act on one operation in the same cycle. The sharpest overlap is a same-sign add that carries out while the shifted operand has already folded bits into sticky. The other is a subtract whose alignment shift feeds a cancellation. The bench provokes these by drawing z with an exponent within one of the product's and with either sign, next to directed exact-carry and deep-cancellation cases. It judges each result against an exact wide-integer model, which computes the true z ± x·y and then extracts the leading 56 bits with sticky.

// File: rtl/fma_dp_pkg.sv
package fma_dp_pkg;
  localparam int MANT_W    = 53;
  localparam int WORD_W    = 64;
  localparam int PROD_W    = 2 * WORD_W;
  localparam int PAD_W     = WORD_W - MANT_W;
  localparam int LEAD_POS  = PROD_W - 2;
  localparam int GRS_W     = 3;
  localparam int SIG_W     = MANT_W + GRS_W;
  localparam int OUT_SHIFT = LEAD_POS - (SIG_W - 1);
  localparam int SH_W      = $clog2(PROD_W) + 1;
  localparam int CNT_W     = $clog2(PROD_W + 1);

  // Right shift that ORs every bit pushed out into bit 0.
  function automatic logic [PROD_W-1:0] shr_sticky(input logic [PROD_W-1:0] v,
                                                   input logic [SH_W-1:0]   amt);
    logic [PROD_W-1:0] lost_mask;
    logic [PROD_W-1:0] res;
    if (amt >= SH_W'(PROD_W)) begin
      res = {{(PROD_W-1){1'b0}}, |v};
    end else begin
      lost_mask = ~({PROD_W{1'b1}} << amt);
      res = (v >> amt) | {{(PROD_W-1){1'b0}}, |(v & lost_mask)};
    end
    return res;
  endfunction
endpackage

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter int W  = 128,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Highest set bit wins because the loop runs upward.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fma_prod_stage.sv
module fma_prod_stage import fma_dp_pkg::*; #(
  parameter int EXP_W = 13,
  parameter int EW    = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     negate_prod,
  input  logic                     round_down,
  input  logic                     x_sign,
  input  logic [EXP_W-1:0]         x_exp,
  input  logic [MANT_W-1:0]        x_mant,
  input  logic                     y_sign,
  input  logic [EXP_W-1:0]         y_exp,
  input  logic [MANT_W-1:0]        y_mant,
  input  logic                     z_sign,
  input  logic [EXP_W-1:0]         z_exp,
  input  logic [MANT_W-1:0]        z_mant,
  input  logic                     z_is_zero,
  output logic                     s1_valid,
  output logic                     s1_psign,
  output logic signed [EW-1:0]     s1_pexp,
  output logic [PROD_W-1:0]        s1_prod,
  output logic                     s1_zsign,
  output logic signed [EW-1:0]     s1_zexp,
  output logic [MANT_W-1:0]        s1_zmant,
  output logic                     s1_zzero,
  output logic                     s1_rd
);
  logic [PROD_W-1:0]    raw;
  logic                 top_bit;
  logic signed [EW-1:0] esum;

  always_comb begin
    raw     = PROD_W'({x_mant, {PAD_W{1'b0}}}) * PROD_W'({y_mant, {PAD_W{1'b0}}});
    top_bit = raw[PROD_W-1];
    esum    = EW'($signed(x_exp)) + EW'($signed(y_exp)) + EW'(top_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  // Low product bits are zero after padding, so the one-bit shift loses nothing.
  always_ff @(posedge clk) begin
    s1_prod  <= top_bit ? (raw >> 1) : raw;
    s1_pexp  <= esum;
    s1_psign <= x_sign ^ y_sign ^ negate_prod;
    s1_zsign <= z_sign;
    s1_zexp  <= EW'($signed(z_exp));
    s1_zmant <= z_mant;
    s1_zzero <= z_is_zero;
    s1_rd    <= round_down;
  end
endmodule

// File: rtl/fma_sum_stage.sv
module fma_sum_stage import fma_dp_pkg::*; #(
  parameter int EXP_W = 13,
  parameter int EW    = EXP_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s1_valid,
  input  logic                 s1_psign,
  input  logic signed [EW-1:0] s1_pexp,
  input  logic [PROD_W-1:0]    s1_prod,
  input  logic                 s1_zsign,
  input  logic signed [EW-1:0] s1_zexp,
  input  logic [MANT_W-1:0]    s1_zmant,
  input  logic                 s1_zzero,
  input  logic                 s1_rd,
  output logic                 out_valid,
  output logic                 out_sign,
  output logic [EW-1:0]        out_exp,
  output logic [SIG_W-1:0]     out_sig
);
  localparam int ZPAD = PROD_W - 1 - MANT_W;

  logic [PROD_W-1:0]    zword, shift_in, shifted, a_z, a_p, sum, dif, norm, w;
  logic signed [EW:0]   ediff;
  logic [EW:0]          mag;
  logic [SH_W-1:0]      amt;
  logic                 zbig, z_ge, dsign, s_n;
  logic signed [EW-1:0] ealn, e_n;
  logic [CNT_W-1:0]     lz, nshift;

  fma_lzc #(.W(PROD_W), .CW(CNT_W)) u_lzc (.vec(dif), .cnt(lz));

  always_comb begin
    zword    = {1'b0, s1_zmant, {ZPAD{1'b0}}};
    ediff    = {s1_zexp[EW-1], s1_zexp} - {s1_pexp[EW-1], s1_pexp};
    zbig     = !ediff[EW] && (ediff != '0);
    mag      = ediff[EW] ? (EW+1)'(-ediff) : (EW+1)'(ediff);
    amt      = (mag >= (EW+1)'(PROD_W)) ? SH_W'(PROD_W) : SH_W'(mag);
    shift_in = zbig ? s1_prod : zword;
    shifted  = shr_sticky(shift_in, amt);
    a_z      = zbig ? zword : shifted;
    a_p      = zbig ? shifted : s1_prod;
    ealn     = zbig ? s1_zexp : s1_pexp;
    sum      = a_z + a_p;
    z_ge     = a_z >= a_p;
    dif      = z_ge ? (a_z - a_p) : (a_p - a_z);
    dsign    = z_ge ? s1_zsign : s1_psign;
    nshift   = lz - CNT_W'(1);
    norm     = dif << nshift;

    w   = s1_prod;
    e_n = s1_pexp;
    s_n = s1_psign;
    if (s1_zzero) begin
      w   = s1_prod;
      e_n = s1_pexp;
      s_n = s1_psign;
    end else if (s1_zsign == s1_psign) begin
      s_n = s1_psign;
      if (sum[PROD_W-1]) begin
        w   = shr_sticky(sum, SH_W'(1));
        e_n = ealn + EW'(1);
      end else begin
        w   = sum;
        e_n = ealn;
      end
    end else if (dif == '0) begin
      w   = '0;
      e_n = '0;
      s_n = s1_rd;
    end else begin
      w   = norm;
      e_n = ealn - EW'(nshift);
      s_n = dsign;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    out_sign <= s_n;
    out_exp  <= e_n;
    out_sig  <= SIG_W'(shr_sticky(w, SH_W'(OUT_SHIFT)));
  end
endmodule

// File: rtl/fma_mant_core.sv
module fma_mant_core import fma_dp_pkg::*; #(
  parameter int EXP_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              negate_prod,
  input  logic              round_down,
  input  logic              x_sign,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [MANT_W-1:0] x_mant,
  input  logic              y_sign,
  input  logic [EXP_W-1:0]  y_exp,
  input  logic [MANT_W-1:0] y_mant,
  input  logic              z_sign,
  input  logic [EXP_W-1:0]  z_exp,
  input  logic [MANT_W-1:0] z_mant,
  input  logic              z_is_zero,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W+1:0]  out_exp,
  output logic [SIG_W-1:0]  out_sig
);
  localparam int EW = EXP_W + 2;

  logic                 s1_valid, s1_psign, s1_zsign, s1_zzero, s1_rd;
  logic signed [EW-1:0] s1_pexp, s1_zexp;
  logic [PROD_W-1:0]    s1_prod;
  logic [MANT_W-1:0]    s1_zmant;

  fma_prod_stage #(.EXP_W(EXP_W), .EW(EW)) u_prod (
    .clk(clk), .rst(rst), .in_valid(in_valid), .negate_prod(negate_prod),
    .round_down(round_down),
    .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
    .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
    .z_sign(z_sign), .z_exp(z_exp), .z_mant(z_mant), .z_is_zero(z_is_zero),
    .s1_valid(s1_valid), .s1_psign(s1_psign), .s1_pexp(s1_pexp), .s1_prod(s1_prod),
    .s1_zsign(s1_zsign), .s1_zexp(s1_zexp), .s1_zmant(s1_zmant),
    .s1_zzero(s1_zzero), .s1_rd(s1_rd)
  );

  fma_sum_stage #(.EXP_W(EXP_W), .EW(EW)) u_sum (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_psign(s1_psign), .s1_pexp(s1_pexp), .s1_prod(s1_prod),
    .s1_zsign(s1_zsign), .s1_zexp(s1_zexp), .s1_zmant(s1_zmant),
    .s1_zzero(s1_zzero), .s1_rd(s1_rd),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
  );
endmodule

// File: rtl/fma_mant_core_chk.sv
module fma_mant_core_chk import fma_dp_pkg::*; #(
  parameter int EXP_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             negate_prod,
  input logic             round_down,
  input logic             x_sign,
  input logic             y_sign,
  input logic             z_is_zero,
  input logic             out_valid,
  input logic             out_sign,
  input logic [EXP_W+1:0] out_exp,
  input logic [SIG_W-1:0] out_sig
);
  logic v1, v2, rd1, rd2, ps1, ps2, zz1, zz2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    rd1 <= round_down;
    rd2 <= rd1;
    ps1 <= x_sign ^ y_sign ^ negate_prod;
    ps2 <= ps1;
    zz1 <= z_is_zero;
    zz2 <= zz1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  // R9
  normalized_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sig != '0) |-> out_sig[SIG_W-1]);

  // R7
  zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sig == '0) |-> (out_sign == rd2 && out_exp == '0 && !zz2));

  // R2
  prod_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zz2) |-> (out_sign == ps2));
endmodule

bind fma_mant_core fma_mant_core_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .negate_prod(negate_prod),
  .round_down(round_down), .x_sign(x_sign), .y_sign(y_sign), .z_is_zero(z_is_zero),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
);

// File: tb/fma_mant_core_bench.sv
module fma_mant_core_bench;
  import fma_dp_pkg::*;
  localparam int EXP_W = 13;
  localparam int EW    = EXP_W + 2;
  localparam int BIG   = 1024;
  localparam logic [MANT_W-1:0] ONE  = 53'h10000000000000;
  localparam logic [MANT_W-1:0] ONE5 = 53'h18000000000000;
  localparam logic [MANT_W-1:0] M9   = 53'h12000000000000;
  localparam logic [MANT_W-1:0] MX   = 53'h15555555555554;
  localparam logic [MANT_W-1:0] MZ   = 53'h1abcdef0123457;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, neg = 1'b0, rd = 1'b0;
  logic xs = 1'b0, ys = 1'b0, zs = 1'b0, zz = 1'b0;
  logic [EXP_W-1:0]  xe = '0, ye = '0, ze = '0;
  logic [MANT_W-1:0] xm = ONE, ym = ONE, zm = ONE;
  logic              out_valid, out_sign;
  logic [EW-1:0]     out_exp;
  logic [SIG_W-1:0]  out_sig;

  int n_chk = 0, n_bad = 0;
  logic             q_sign[$];
  int               q_exp[$];
  logic [SIG_W-1:0] q_sig[$];
  string            q_tag[$];

  always #5 clk = ~clk;

  fma_mant_core #(.EXP_W(EXP_W)) u_fma_mant_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .negate_prod(neg), .round_down(rd),
    .x_sign(xs), .x_exp(xe), .x_mant(xm), .y_sign(ys), .y_exp(ye), .y_mant(ym),
    .z_sign(zs), .z_exp(ze), .z_mant(zm), .z_is_zero(zz),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
  );

  // Exact wide-integer model of z +/- x*y, then leading 56 bits with sticky.
  function automatic void ref_fma(
    input logic a_s, input int a_e, input logic [MANT_W-1:0] a_m,
    input logic b_s, input int b_e, input logic [MANT_W-1:0] b_m,
    input logic c_s, input int c_e, input logic [MANT_W-1:0] c_m,
    input logic c_zero, input logic ng, input logic rdn,
    output logic r_s, output int r_e, output logic [SIG_W-1:0] r_sig);
    logic [BIG-1:0] p, z, r, lowmask;
    int pe, zb, emin, k;
    logic ps;
    ps = a_s ^ b_s ^ ng;
    p  = BIG'(a_m) * BIG'(b_m);
    pe = a_e + b_e - 2 * (MANT_W - 1);
    r_s = ps;
    if (c_zero) begin
      r = p; emin = pe;
    end else begin
      zb   = c_e - (MANT_W - 1);
      emin = (pe < zb) ? pe : zb;
      p = p << (pe - emin);
      z = BIG'(c_m) << (zb - emin);
      if (ps == c_s) r = p + z;
      else if (z >= p) begin r = z - p; r_s = c_s; end
      else r = p - z;
    end
    if (r == '0) begin
      r_s = rdn; r_e = 0; r_sig = '0;
    end else begin
      k = 0;
      for (int i = 0; i < BIG; i++) if (r[i]) k = i;
      r_e = emin + k;
      if (k >= SIG_W - 1) begin
        lowmask = (BIG'(1) << (k - (SIG_W - 1))) - BIG'(1);
        r_sig = SIG_W'(r >> (k - (SIG_W - 1)));
        if ((r & lowmask) != '0) r_sig[0] = 1'b1;
      end else begin
        r_sig = SIG_W'(r << ((SIG_W - 1) - k));
      end
    end
  endfunction

  task automatic issue_exp(
    input logic a_s, input int a_e, input logic [MANT_W-1:0] a_m,
    input logic b_s, input int b_e, input logic [MANT_W-1:0] b_m,
    input logic c_s, input int c_e, input logic [MANT_W-1:0] c_m,
    input logic c_zero, input logic ng, input logic rdn,
    input logic e_s, input int e_e, input logic [SIG_W-1:0] e_sig, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    xs = a_s; xe = EXP_W'(a_e); xm = a_m;
    ys = b_s; ye = EXP_W'(b_e); ym = b_m;
    zs = c_s; ze = EXP_W'(c_e); zm = c_m;
    zz = c_zero; neg = ng; rd = rdn;
    q_sign.push_back(e_s); q_exp.push_back(e_e); q_sig.push_back(e_sig); q_tag.push_back(tag);
  endtask

  task automatic issue(
    input logic a_s, input int a_e, input logic [MANT_W-1:0] a_m,
    input logic b_s, input int b_e, input logic [MANT_W-1:0] b_m,
    input logic c_s, input int c_e, input logic [MANT_W-1:0] c_m,
    input logic c_zero, input logic ng, input logic rdn, input string tag);
    logic e_s; int e_e; logic [SIG_W-1:0] e_sig;
    ref_fma(a_s, a_e, a_m, b_s, b_e, b_m, c_s, c_e, c_m, c_zero, ng, rdn, e_s, e_e, e_sig);
    issue_exp(a_s, a_e, a_m, b_s, b_e, b_m, c_s, c_e, c_m, c_zero, ng, rdn, e_s, e_e, e_sig, tag);
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin : monitor
    logic es; int ee; logic [SIG_W-1:0] esig; string t; int got_e;
    if (!rst && out_valid) begin
      n_chk++;
      if (q_sig.size() == 0) begin
        n_bad++;
        $display("FAIL R1 spurious result: got out_valid=1 expected 0");
      end else begin
        es = q_sign.pop_front(); ee = q_exp.pop_front();
        esig = q_sig.pop_front(); t = q_tag.pop_front();
        got_e = int'($signed(out_exp));
        if (out_sign !== es || got_e != ee || out_sig !== esig) begin
          n_bad++;
          $display("FAIL %s: got s=%0b e=%0d sig=%h expected s=%0b e=%0d sig=%h",
                   t, out_sign, got_e, out_sig, es, ee, esig);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [MANT_W-1:0] ma, mb, mc;
    logic e_s; int e_e; logic [SIG_W-1:0] e_sig;
    int a_e, b_e, c_e;
    logic c_s, c_z;
    void'($urandom(32'd2024));
    // R1: inputs during reset produce nothing
    repeat (2) @(negedge clk);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset: got out_valid=%0b expected 0", out_valid);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    gap();

    // R2: z zero passes product, with and without negate
    issue(0, 0, ONE5, 0, 0, ONE5, 0, 0, ONE, 1, 0, 0, "R2 product only");
    issue(1, 3, M9, 0, -7, ONE5, 0, 0, ONE, 1, 1, 0, "R2 negated product");
    // R3: z fields ignored when z is zero
    issue(0, 2, ONE5, 1, 1, M9, 1, 40, MZ, 1, 0, 0, "R3 z ignored a");
    issue(0, 2, ONE5, 1, 1, M9, 0, -300, MX, 1, 0, 0, "R3 z ignored b");
    gap();
    // R5: carry out of same-sign sum (2.25 + 2.25)
    issue(0, 0, ONE5, 0, 0, ONE5, 0, 1, M9, 0, 0, 0, "R5 carry");
    // R6: larger magnitude sets sign
    issue(0, 1, ONE, 0, 1, ONE, 1, 0, ONE, 0, 0, 0, "R6 product larger");
    issue(0, 0, ONE, 0, 0, ONE, 1, 3, ONE, 0, 0, 0, "R6 z larger");
    gap();
    // R7: exact cancel, sign from rounding direction
    issue(0, 0, ONE, 0, 3, MX, 1, 3, MX, 0, 0, 0, "R7 cancel rd=0");
    issue(0, 0, ONE, 0, 3, MX, 1, 3, MX, 0, 0, 1, "R7 cancel rd=1");
    issue(0, 0, ONE, 0, 3, MX, 0, 3, MX, 0, 1, 1, "R7 cancel via negate");
    // R9: deep cancellation
    issue(0, 0, ONE, 0, 0, MX, 1, 0, MX + 53'd1, 0, 0, 0, "R9 deep cancel");
    gap();
    // R8: far alignment
    issue_exp(0, 0, ONE5, 0, 0, ONE5, 0, 1000, MZ, 0, 0, 0,
              1'b0, 1000, {MZ, 3'b001}, "R8 far product same sign");
    issue_exp(0, 0, ONE5, 0, 0, ONE5, 1, 1000, MZ, 0, 0, 0,
              1'b1, 1000, {MZ - 53'd1, 3'b111}, "R8 far product opposite sign");
    ref_fma(0, 600, ONE5, 0, 600, ONE5, 0, 0, ONE, 1, 0, 0, e_s, e_e, e_sig);
    issue_exp(0, 600, ONE5, 0, 600, ONE5, 0, 0, MZ, 0, 0, 0,
              e_s, e_e, e_sig | 56'd1, "R8 far z same sign");
    gap();
    // R10: back-to-back burst
    issue(0, 1, MX, 1, 2, MZ, 0, 3, ONE5, 0, 0, 0, "R10 burst 0");
    issue(1, -4, MZ, 0, 5, MX, 0, 2, M9, 0, 1, 0, "R10 burst 1");
    issue(0, 7, M9, 0, -7, ONE5, 1, 0, MX, 0, 0, 1, "R10 burst 2");
    issue(1, 0, ONE5, 1, 0, MX, 1, 1, MZ, 0, 0, 0, "R10 burst 3");
    gap();

    // R4 R10: random, with near-cancel and z-zero mixes
    for (int n = 0; n < 400; n++) begin
      ma = {1'b1, 20'($urandom), 32'($urandom)};
      mb = {1'b1, 20'($urandom), 32'($urandom)};
      mc = {1'b1, 20'($urandom), 32'($urandom)};
      a_e = int'($urandom_range(40)) - 20;
      b_e = int'($urandom_range(40)) - 20;
      c_e = int'($urandom_range(120)) - 60;
      c_s = 1'($urandom);
      c_z = ($urandom_range(7) == 0);
      if ($urandom_range(2) == 0) c_e = a_e + b_e + int'($urandom_range(2)) - 1;
      issue(1'($urandom), a_e, ma, 1'($urandom), b_e, mb, c_s, c_e, mc, c_z,
            1'($urandom), 1'($urandom), "R4 R10 random");
      if ($urandom_range(3) == 0) gap();
    end
    repeat (6) gap();
    n_chk++;
    if (q_sig.size() != 0) begin
      n_bad++; $display("FAIL R10 drain: got %0d pending expected 0", q_sig.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule